// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block is the counting heart of a real-time clock. A tick input advances a chain of packed-BCD counters. The chain runs from seconds through minutes, hours (24-hour), day of the week, day of the month, month, two-digit year and a century counter. The day-of-month limit follows the current month. February gains a 29th day whenever the two-digit year is a multiple of four, and that rule holds until the year 2100.

A tick divider sits in front of the chain. `TICK_DIV` tick pulses make one second, and with the default of 1 every tick is one second. A stop input freezes the divider and every counter. A load strobe writes a complete new date and time in one clock cycle and clears the divider. Every field is visible at all times on its own output byte.

Top module: `cal_clock_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs become century 0x20, year 0x00, month 0x01, date 0x01, weekday 0x01, hour 0x00, minute 0x00, second 0x00.
- R2: Each field is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. Seconds step by one per second and carry from units to tens (0x09 to 0x10). From 0x59 they go to 0x00 and the minute steps in the same update.
- R3: Minutes go from 0x59 to 0x00 and advance the hour. Hours go from 0x23 to 0x00 and advance both the date and the weekday.
- R4: The weekday counts 0x01 to 0x07 and then returns to 0x01 at midnight, whatever the date does.
- R5: The last date is 0x30 for months 0x04, 0x06, 0x09 and 0x11, and 0x31 for the other months apart from February. Past the last date, the date returns to 0x01 and the month advances.
- R6: February ends on 0x29 when the year's value is a multiple of four (year 0x00 included), and on 0x28 otherwise.
- R7: Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00 and advances the century. Century 0x39 wraps to 0x00.
- R8: While `osc_stop` is 1, ticks are ignored. Every field and the partial-second count hold, so counting resumes where it left off.
- R9: A `load_en` cycle replaces all eight fields with the `set_*` bytes at the next edge and clears the partial-second count. A tick in the same cycle is discarded.
- R10: One second elapses per `TICK_DIV` accepted ticks. Fewer ticks leave the seconds unchanged.
- R11: A date loaded beyond the current month's last day returns to 0x01 at the next day carry, and the month advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | One-cycle pulse from the prescaler |
| osc_stop | input | 1 | 1 freezes the divider and all counters |
| load_en | input | 1 | One-cycle strobe that writes all set_* fields |
| set_sec | input | 8 | Seconds value to load, BCD |
| set_min | input | 8 | Minutes value to load, BCD |
| set_hour | input | 8 | Hours value to load, BCD |
| set_wday | input | 8 | Weekday value to load, BCD 01-07 |
| set_mday | input | 8 | Date value to load, BCD |
| set_month | input | 8 | Month value to load, BCD |
| set_year | input | 8 | Year value to load, BCD |
| set_cent | input | 8 | Century value to load, BCD |
| cur_sec | output | 8 | Current seconds |
| cur_min | output | 8 | Current minutes |
| cur_hour | output | 8 | Current hours |
| cur_wday | output | 8 | Current weekday |
| cur_mday | output | 8 | Current date |
| cur_month | output | 8 | Current month |
| cur_year | output | 8 | Current year |
| cur_cent | output | 8 | Current century |

## Verification
The bench builds the core with `TICK_DIV = 2`. That setting gives the divider real partial-second state, so stop, resume and load-clearing of an unfinished second can all be observed at the ports. Using loads to jump straight to the edges of the calendar, it sweeps a full hour of seconds, every month end in a common year, the February end in all hundred years, and all seven weekday rollovers. It also covers the year and century wraps and an out-of-range date.

// File: rtl/cal_pkg.sv
// Shared helpers for the calendar core: BCD increment, leap-year test and
// month-length lookup. All values are packed BCD (tens in [7:4]).
package cal_pkg;

    // Next BCD value; assumes a valid BCD input below 0x99.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Year is a multiple of four: 10 = 2 (mod 4), so check 2*tens + units.
    function automatic logic is_leap(input logic [7:0] yr);
        logic [1:0] s;
        s = {yr[4], 1'b0} + yr[1:0];
        return (s == 2'd0);
    endfunction

    // Last valid date of the given month.
    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_tick_div.sv
// Turns prescaler ticks into a one-cycle second strobe.
// Assumes: tick_in is a single-cycle pulse; clear has priority over ticks.
module cal_tick_div #(
    parameter int TICK_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic run,
    input  logic clear,
    output logic sec_pulse
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    generate
        if (TICK_DIV <= 1) begin : g_direct
            // Every accepted tick is a full second.
            assign sec_pulse = tick_in && run && !clear;
        end else begin : g_count
            logic [CW-1:0] sub_q;

            assign sec_pulse = tick_in && run && !clear && (sub_q == LAST);

            // Partial-second counter: cleared by load, held while stopped.
            always_ff @(posedge clk) begin
                if (!rst_n || clear)
                    sub_q <= '0;
                else if (tick_in && run)
                    sub_q <= (sub_q == LAST) ? '0 : sub_q + CW'(1);
            end

            always_ff @(posedge clk) begin
                if (rst_n) assert_sub_range_R10: assert (sub_q <= LAST);
            end

            assert_sub_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (!run && !clear) |=> $stable(sub_q));
        end
    endgenerate
endmodule

// File: rtl/cal_bcd_field.sv
// One BCD calendar field: loads, increments, and wraps to FIRST once the
// value reaches or passes `last`. Assumes valid BCD contents.
module cal_bcd_field #(
    parameter logic [7:0] FIRST     = 8'h00,
    parameter logic [7:0] RESET_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic [7:0] last,
    output logic [7:0] val,
    output logic       wrap
);
    import cal_pkg::*;

    assign wrap = inc && !load && (val >= last);

    // Field register: reset, load, wrap or step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            val <= RESET_VAL;
        else if (load)
            val <= load_val;
        else if (inc)
            val <= (val >= last) ? FIRST : bcd_inc(val);
    end

    assert_field_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(val));

    assert_field_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && val >= last) |=> (val == FIRST));
endmodule

// File: rtl/cal_clock_core.sv
// BCD calendar clock core: divider plus a carry chain of eight BCD fields,
// all carries settling in the cycle of the second strobe. Assumes 24-hour
// time and the multiple-of-four leap rule (valid until 2100).
module cal_clock_core #(
    parameter int TICK_DIV = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_in,
    input  logic       osc_stop,
    input  logic       load_en,
    input  logic [7:0] set_sec,
    input  logic [7:0] set_min,
    input  logic [7:0] set_hour,
    input  logic [7:0] set_wday,
    input  logic [7:0] set_mday,
    input  logic [7:0] set_month,
    input  logic [7:0] set_year,
    input  logic [7:0] set_cent,
    output logic [7:0] cur_sec,
    output logic [7:0] cur_min,
    output logic [7:0] cur_hour,
    output logic [7:0] cur_wday,
    output logic [7:0] cur_mday,
    output logic [7:0] cur_month,
    output logic [7:0] cur_year,
    output logic [7:0] cur_cent
);
    import cal_pkg::*;

    logic sec_pulse;
    logic sec_wrap, min_wrap, hour_wrap, wday_wrap, mday_wrap, month_wrap, year_wrap, cent_wrap;
    logic [7:0] mday_last;

    // Month length follows the current month and year.
    assign mday_last = month_last(cur_month, is_leap(cur_year));

    cal_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .run(!osc_stop),
        .clear(load_en), .sec_pulse(sec_pulse)
    );

    cal_bcd_field #(.FIRST(8'h00), .RESET_VAL(8'h00)) u_sec (
        .clk(clk), .rst_n(rst_n), .inc(sec_pulse), .load(load_en), .load_val(set_sec),
        .last(8'h59), .val(cur_sec), .wrap(sec_wrap));

    cal_bcd_field #(.FIRST(8'h00), .RESET_VAL(8'h00)) u_min (
        .clk(clk), .rst_n(rst_n), .inc(sec_wrap), .load(load_en), .load_val(set_min),
        .last(8'h59), .val(cur_min), .wrap(min_wrap));

    cal_bcd_field #(.FIRST(8'h00), .RESET_VAL(8'h00)) u_hour (
        .clk(clk), .rst_n(rst_n), .inc(min_wrap), .load(load_en), .load_val(set_hour),
        .last(8'h23), .val(cur_hour), .wrap(hour_wrap));

    cal_bcd_field #(.FIRST(8'h01), .RESET_VAL(8'h01)) u_wday (
        .clk(clk), .rst_n(rst_n), .inc(hour_wrap), .load(load_en), .load_val(set_wday),
        .last(8'h07), .val(cur_wday), .wrap(wday_wrap));

    cal_bcd_field #(.FIRST(8'h01), .RESET_VAL(8'h01)) u_mday (
        .clk(clk), .rst_n(rst_n), .inc(hour_wrap), .load(load_en), .load_val(set_mday),
        .last(mday_last), .val(cur_mday), .wrap(mday_wrap));

    cal_bcd_field #(.FIRST(8'h01), .RESET_VAL(8'h01)) u_month (
        .clk(clk), .rst_n(rst_n), .inc(mday_wrap), .load(load_en), .load_val(set_month),
        .last(8'h12), .val(cur_month), .wrap(month_wrap));

    cal_bcd_field #(.FIRST(8'h00), .RESET_VAL(8'h00)) u_year (
        .clk(clk), .rst_n(rst_n), .inc(month_wrap), .load(load_en), .load_val(set_year),
        .last(8'h99), .val(cur_year), .wrap(year_wrap));

    cal_bcd_field #(.FIRST(8'h00), .RESET_VAL(8'h20)) u_cent (
        .clk(clk), .rst_n(rst_n), .inc(year_wrap), .load(load_en), .load_val(set_cent),
        .last(8'h39), .val(cur_cent), .wrap(cent_wrap));

    assert_load_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (cur_sec == $past(set_sec) && cur_min == $past(set_min) &&
                     cur_hour == $past(set_hour) && cur_wday == $past(set_wday) &&
                     cur_mday == $past(set_mday) && cur_month == $past(set_month) &&
                     cur_year == $past(set_year) && cur_cent == $past(set_cent)));

    assert_stop_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop && !load_en) |=> ($stable(cur_sec) && $stable(cur_min) &&
                                    $stable(cur_hour) && $stable(cur_mday) &&
                                    $stable(cur_month) && $stable(cur_year)));

    assert_midnight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (min_wrap && cur_hour == 8'h23) |=> (cur_hour == 8'h00 && cur_min == 8'h00));

    assert_wday_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_wrap && !load_en && cur_wday == 8'h07) |=> (cur_wday == 8'h01));
endmodule

// File: tb/cal_clock_core_bench.sv
module cal_clock_core_bench;
    localparam int TD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_in = 1'b0, osc_stop = 1'b0, load_en = 1'b0;
    logic [7:0] set_sec = '0, set_min = '0, set_hour = '0, set_wday = '0;
    logic [7:0] set_mday = '0, set_month = '0, set_year = '0, set_cent = '0;
    logic [7:0] cur_sec, cur_min, cur_hour, cur_wday, cur_mday, cur_month, cur_year, cur_cent;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    cal_clock_core #(.TICK_DIV(TD)) u_cal_clock_core (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .osc_stop(osc_stop), .load_en(load_en),
        .set_sec(set_sec), .set_min(set_min), .set_hour(set_hour), .set_wday(set_wday),
        .set_mday(set_mday), .set_month(set_month), .set_year(set_year), .set_cent(set_cent),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_wday(cur_wday),
        .cur_mday(cur_mday), .cur_month(cur_month), .cur_year(cur_year), .cur_cent(cur_cent));

    function automatic logic [7:0] bcd(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic int mlen(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input int c, input int y, input int mo, input int d,
                           input int wd, input int h, input int mi, input int s);
        @(negedge clk);
        load_en = 1'b1;
        set_cent = bcd(c); set_year = bcd(y); set_month = bcd(mo); set_mday = bcd(d);
        set_wday = bcd(wd); set_hour = bcd(h); set_min = bcd(mi); set_sec = bcd(s);
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1'b1;
            @(negedge clk); tick_in = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cent", cur_cent, 8'h20);  chk("R1 year", cur_year, 8'h00);
        chk("R1 month", cur_month, 8'h01); chk("R1 mday", cur_mday, 8'h01);
        chk("R1 wday", cur_wday, 8'h01);  chk("R1 hour", cur_hour, 8'h00);
        chk("R1 min", cur_min, 8'h00);    chk("R1 sec", cur_sec, 8'h00);

        // R10 a partial second leaves seconds unchanged
        pulse(1);
        chk("R10 half second", cur_sec, 8'h00);
        pulse(1);
        chk("R10 full second", cur_sec, 8'h01);

        // R2 / R3 one full hour, second by second
        do_load(20, 0, 1, 1, 1, 0, 0, 0);
        for (int s = 1; s <= 3600; s++) begin
            pulse(TD);
            chk("R2 sec", cur_sec, bcd(s % 60));
            chk("R2 min", cur_min, bcd((s / 60) % 60));
            chk("R3 hour", cur_hour, bcd(s / 3600));
        end

        // R3 R4 R5 R7 new year's eve, 2099 -> 2100
        do_load(20, 99, 12, 31, 7, 23, 59, 59);
        pulse(TD);
        chk("R3 hour", cur_hour, 8'h00); chk("R3 min", cur_min, 8'h00);
        chk("R2 sec", cur_sec, 8'h00);   chk("R4 wday", cur_wday, 8'h01);
        chk("R5 mday", cur_mday, 8'h01); chk("R7 month", cur_month, 8'h01);
        chk("R7 year", cur_year, 8'h00); chk("R7 cent", cur_cent, 8'h21);

        // R7 century wrap
        do_load(39, 99, 12, 31, 3, 23, 59, 59);
        pulse(TD);
        chk("R7 cent wrap", cur_cent, 8'h00);
        chk("R7 year wrap", cur_year, 8'h00);

        // R5 every month end in a common year
        for (int m = 1; m <= 12; m++) begin
            do_load(20, 1, m, mlen(m, 1) - 1, 2, 23, 59, 59);
            pulse(TD);
            chk("R5 last day", cur_mday, bcd(mlen(m, 1)));
            chk("R5 same month", cur_month, bcd(m));
            do_load(20, 1, m, mlen(m, 1), 2, 23, 59, 59);
            pulse(TD);
            chk("R5 wrap date", cur_mday, 8'h01);
            chk("R5 next month", cur_month, bcd(m == 12 ? 1 : m + 1));
        end

        // R6 February end in every year
        for (int y = 0; y <= 99; y++) begin
            do_load(20, y, 2, 28, 4, 23, 59, 59);
            pulse(TD);
            chk("R6 feb date", cur_mday, (y % 4 == 0) ? 8'h29 : 8'h01);
            chk("R6 feb month", cur_month, (y % 4 == 0) ? 8'h02 : 8'h03);
        end

        // R4 weekday rollover for each day, date unaffected
        for (int d = 1; d <= 7; d++) begin
            do_load(20, 5, 6, 10, d, 23, 59, 59);
            pulse(TD);
            chk("R4 wday", cur_wday, bcd(d == 7 ? 1 : d + 1));
            chk("R4 date indep", cur_mday, 8'h11);
        end

        // R8 stop freezes fields and partial second
        do_load(20, 10, 3, 3, 3, 12, 0, 30);
        pulse(1);
        @(negedge clk); osc_stop = 1'b1;
        pulse(5);
        chk("R8 stopped sec", cur_sec, 8'h30);
        chk("R8 stopped hour", cur_hour, 8'h12);
        @(negedge clk); osc_stop = 1'b0;
        pulse(1);
        chk("R8 resume partial", cur_sec, 8'h31);

        // R9 load clears the partial second
        pulse(1);
        do_load(20, 10, 3, 3, 3, 10, 0, 0);
        pulse(1);
        chk("R9 cleared partial", cur_sec, 8'h00);
        pulse(1);
        chk("R9 after clear", cur_sec, 8'h01);

        // R9 load wins over a simultaneous tick
        pulse(1);
        @(negedge clk);
        load_en = 1'b1; tick_in = 1'b1;
        set_cent = 8'h20; set_year = 8'h44; set_month = 8'h07; set_mday = 8'h15;
        set_wday = 8'h05; set_hour = 8'h08; set_min = 8'h09; set_sec = 8'h10;
        @(negedge clk);
        load_en = 1'b0; tick_in = 1'b0;
        chk("R9 load sec", cur_sec, 8'h10);   chk("R9 load min", cur_min, 8'h09);
        chk("R9 load hour", cur_hour, 8'h08); chk("R9 load wday", cur_wday, 8'h05);
        chk("R9 load mday", cur_mday, 8'h15); chk("R9 load month", cur_month, 8'h07);
        chk("R9 load year", cur_year, 8'h44); chk("R9 load cent", cur_cent, 8'h20);
        pulse(1);
        chk("R9 partial cleared with tick", cur_sec, 8'h10);

        // R11 out-of-range date recovers
        do_load(20, 3, 4, 31, 1, 23, 59, 59);
        pulse(TD);
        chk("R11 date", cur_mday, 8'h01);
        chk("R11 month", cur_month, 8'h05);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule